// File: doc/BRIEF.md
# Streaming Bytecode Instruction Delimiter

This block sits on a byte stream and splits it into instruction records. Bytes arrive on a valid/ready input, each one tagged with a 16-bit address. The address counts up by one for every accepted byte, and it starts from a value that is loaded through a strobe. Records leave on a valid/ready output, one per instruction. A record carries the opcode, up to two operand bytes, the instruction length, the address of the first byte and, for branches, the resolved branch target.

After reset the block is in pass-through mode. In this mode every byte leaves as a one-byte record flagged as foreign code. When a configurable multi-byte entry marker appears, the marker bytes are still forwarded as foreign code. Decoding then starts with the byte that follows the marker, and it stops after the exit opcode. The length of each instruction comes from its opcode class. Opcodes with high nibble 1 carry a two-byte immediate. Most opcodes with high nibble 0 are branches that carry one signed displacement byte. All other opcodes are one byte long. Three opcode values have no defined meaning. They are reported with an error flag and decoding carries on.

Top module: `instr_delimiter`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and the block is in pass-through mode.
- R2: In pass-through mode, each accepted byte produces one record with outForeign=1, outLen=1, outHasTarget=0, outUndef=0, outOpcode equal to the byte, outOperand=0 and outAddr equal to the byte's address.
- R3: The entry marker is matched when the last MARK_BYTES pass-through bytes, oldest byte in the most significant position, equal MARKER (default A5 5A C3). The marker bytes are forwarded as foreign records, and the next byte is decoded. A sequence that only partly matches leaves the block in pass-through mode.
- R4: In decode mode, an opcode 10..1F forms a 3-byte record. outLen=3 and outOperand = {third byte, second byte}, so the low byte comes first in the stream.
- R5: In decode mode, opcodes 01..09 and 0C form a 2-byte record with outLen=2, outOperand = {8'h00, displacement} and outHasTarget=1. outTarget = (address of displacement byte + 1 + sign-extended displacement) mod 2^16.
- R6: In decode mode, opcodes 00, 0A, 0B and 20..FF form 1-byte records with outForeign=0 and outHasTarget=0.
- R7: In decode mode, opcodes 0D..0F form 1-byte records with outUndef=1, and decoding continues with the next byte.
- R8: Opcode 00 in decode mode is emitted as a decoded record, and the byte after it is again a foreign record.
- R9: Accepted bytes take consecutive addresses, which wrap modulo 2^16. A loadAddr pulse makes startAddr the address of the next accepted byte. A byte accepted in the same cycle as the pulse keeps the old address.
- R10: While outValid=1 and outReady=0, the record stays stable and no input byte is taken. A byte offered during the stall is accepted later without loss.
- R11: For multi-byte records, outAddr is the address of the opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadAddr | input | 1 | Load startAddr as the address of the next byte |
| startAddr | input | 16 | Start address value |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte can be accepted |
| inByte | input | 8 | Input byte |
| outValid | output | 1 | Record valid |
| outReady | input | 1 | Record consumer ready |
| outForeign | output | 1 | Record is a pass-through byte |
| outUndef | output | 1 | Record is an undefined opcode |
| outHasTarget | output | 1 | outTarget is meaningful |
| outLen | output | 2 | Instruction length in bytes (1..3) |
| outOpcode | output | 8 | Opcode or forwarded byte |
| outOperand | output | 16 | Operand bytes, high byte last received |
| outTarget | output | 16 | Branch target address |
| outAddr | output | 16 | Address of the first byte of the record |

## Verification
Two functions can act in the same clock edge: the address load and the acceptance of a byte. The bench drives a loadAddr pulse together with a valid byte. It then expects that byte's record to carry the old running address and the following byte to carry startAddr. A second overlap happens when a stalled record is released while a waiting byte is accepted in the same edge. Both records must then come out in order, and neither may be lost.

// File: rtl/instr_delim_pkg.sv
package instr_delim_pkg;

  localparam logic [7:0] EXIT_OP = 8'h00;

  typedef struct packed {
    logic       take;
    logic       latchOp;
    logic       latchLo;
    logic       emit;
    logic       foreign;
    logic [1:0] len;
    logic       withTarget;
    logic       undef;
  } delimStrobe_t;

  function automatic logic [1:0] opLength(input logic [7:0] op);
    if (op[7:4] == 4'h1) return 2'd3;
    if (op[7:4] == 4'h0 &&
        ((op[3:0] >= 4'h1 && op[3:0] <= 4'h9) || op[3:0] == 4'hC)) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic opUndefined(input logic [7:0] op);
    return (op[7:4] == 4'h0) && (op[3:0] >= 4'hD);
  endfunction

endpackage

// File: rtl/instr_delim_ctrl.sv
module instr_delim_ctrl
  import instr_delim_pkg::*;
#(
  parameter int MARK_BYTES = 3,
  parameter logic [8*MARK_BYTES-1:0] MARKER = 24'hA55AC3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   inByte,
  input  logic         outValid,
  input  logic         outReady,
  output logic         inReady,
  output delimStrobe_t strb
);

  localparam int HIST_W = 8 * (MARK_BYTES - 1);
  localparam int CNT_W  = $clog2(MARK_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MARK_BYTES - 1);

  typedef enum logic {MODE_PASS, MODE_DEC} mode_t;

  mode_t             mode;
  logic [1:0]        stage;
  logic [1:0]        needLen;
  logic [HIST_W-1:0] hist;
  logic [CNT_W-1:0]  histCnt;
  logic              take;
  logic              markerHit;
  logic [1:0]        byteLen;

  assign inReady   = !outValid || outReady;
  assign take      = inValid && inReady;
  assign byteLen   = opLength(inByte);
  assign markerHit = (mode == MODE_PASS) && (histCnt == CNT_MAX) &&
                     ({hist, inByte} == MARKER);

  always_comb begin
    strb      = '0;
    strb.take = take;
    if (take) begin
      if (mode == MODE_PASS) begin
        strb.emit    = 1'b1;
        strb.foreign = 1'b1;
        strb.len     = 2'd1;
      end else begin
        case (stage)
          2'd0: begin
            if (byteLen == 2'd1) begin
              strb.emit  = 1'b1;
              strb.len   = 2'd1;
              strb.undef = opUndefined(inByte);
            end else begin
              strb.latchOp = 1'b1;
            end
          end
          2'd1: begin
            if (needLen == 2'd2) begin
              strb.emit       = 1'b1;
              strb.len        = 2'd2;
              strb.withTarget = 1'b1;
            end else begin
              strb.latchLo = 1'b1;
            end
          end
          default: begin
            strb.emit = 1'b1;
            strb.len  = 2'd3;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_PASS;
      stage   <= 2'd0;
      needLen <= 2'd1;
      hist    <= '0;
      histCnt <= '0;
    end else if (take) begin
      if (mode == MODE_PASS) begin
        hist <= HIST_W'({hist, inByte});
        if (markerHit) begin
          mode    <= MODE_DEC;
          stage   <= 2'd0;
          histCnt <= '0;
        end else if (histCnt != CNT_MAX) begin
          histCnt <= histCnt + 1'b1;
        end
      end else begin
        case (stage)
          2'd0: begin
            if (byteLen != 2'd1) begin
              stage   <= 2'd1;
              needLen <= byteLen;
            end else if (inByte == EXIT_OP) begin
              mode    <= MODE_PASS;
              histCnt <= '0;
            end
          end
          2'd1:    stage <= (needLen == 2'd2) ? 2'd0 : 2'd2;
          default: stage <= 2'd0;
        endcase
      end
    end
  end

endmodule

// File: rtl/instr_delim_dp.sv
module instr_delim_dp
  import instr_delim_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        inByte,
  input  delimStrobe_t      strb,
  input  logic              outReady,
  output logic              outValid,
  output logic              outForeign,
  output logic              outUndef,
  output logic              outHasTarget,
  output logic [1:0]        outLen,
  output logic [7:0]        outOpcode,
  output logic [15:0]       outOperand,
  output logic [ADDR_W-1:0] outTarget,
  output logic [ADDR_W-1:0] outAddr
);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] instAddr;
  logic [7:0]        opReg;
  logic [7:0]        loReg;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] branchDest;

  assign dispExt    = {{(ADDR_W-8){inByte[7]}}, inByte};
  assign branchDest = curAddr + ADDR_W'(1) + dispExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      instAddr <= '0;
      opReg    <= '0;
      loReg    <= '0;
    end else begin
      if (loadAddr)       curAddr <= startAddr;
      else if (strb.take) curAddr <= curAddr + ADDR_W'(1);
      if (strb.latchOp) begin
        opReg    <= inByte;
        instAddr <= curAddr;
      end
      if (strb.latchLo) loReg <= inByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outForeign   <= 1'b0;
      outUndef     <= 1'b0;
      outHasTarget <= 1'b0;
      outLen       <= 2'd0;
      outOpcode    <= '0;
      outOperand   <= '0;
      outTarget    <= '0;
      outAddr      <= '0;
    end else if (strb.emit) begin
      outValid     <= 1'b1;
      outForeign   <= strb.foreign;
      outUndef     <= strb.undef;
      outHasTarget <= strb.withTarget;
      outLen       <= strb.len;
      outOpcode    <= (strb.len == 2'd1) ? inByte : opReg;
      outOperand   <= (strb.len == 2'd3) ? {inByte, loReg} :
                      (strb.len == 2'd2) ? {8'h00, inByte} : 16'h0000;
      outTarget    <= strb.withTarget ? branchDest : '0;
      outAddr      <= (strb.len == 2'd1) ? curAddr : instAddr;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/instr_delimiter.sv
module instr_delimiter
  import instr_delim_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MARK_BYTES = 3,
  parameter logic [8*MARK_BYTES-1:0] MARKER = 24'hA55AC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inByte,
  output logic              outValid,
  input  logic              outReady,
  output logic              outForeign,
  output logic              outUndef,
  output logic              outHasTarget,
  output logic [1:0]        outLen,
  output logic [7:0]        outOpcode,
  output logic [15:0]       outOperand,
  output logic [ADDR_W-1:0] outTarget,
  output logic [ADDR_W-1:0] outAddr
);

  delimStrobe_t strb;

  instr_delim_ctrl #(
    .MARK_BYTES(MARK_BYTES),
    .MARKER    (MARKER)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inByte  (inByte),
    .outValid(outValid),
    .outReady(outReady),
    .inReady (inReady),
    .strb    (strb)
  );

  instr_delim_dp #(
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .loadAddr    (loadAddr),
    .startAddr   (startAddr),
    .inByte      (inByte),
    .strb        (strb),
    .outReady    (outReady),
    .outValid    (outValid),
    .outForeign  (outForeign),
    .outUndef    (outUndef),
    .outHasTarget(outHasTarget),
    .outLen      (outLen),
    .outOpcode   (outOpcode),
    .outOperand  (outOperand),
    .outTarget   (outTarget),
    .outAddr     (outAddr)
  );

endmodule

// File: rtl/instr_delimiter_chk.sv
module instr_delimiter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outForeign,
  input logic              outUndef,
  input logic              outHasTarget,
  input logic [1:0]        outLen,
  input logic [7:0]        outOpcode,
  input logic [15:0]       outOperand,
  input logic [ADDR_W-1:0] outTarget,
  input logic [ADDR_W-1:0] outAddr
);

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLen != 2'd0)); // R6

  AST_FOREIGN_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outForeign) |-> (outLen == 2'd1 && !outHasTarget && !outUndef)); // R2

  AST_TARGET_IS_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHasTarget) |-> (outLen == 2'd2 && outOperand[15:8] == 8'h00)); // R5

  AST_IMM_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outForeign && outOpcode[7:4] == 4'h1) |-> (outLen == 2'd3)); // R4

  AST_UNDEF_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUndef) |-> (outLen == 2'd1 && !outForeign &&
                                outOpcode[7:4] == 4'h0 && outOpcode[3:0] >= 4'hD)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outOpcode) && $stable(outAddr) &&
                                 $stable(outOperand) && $stable(outTarget) &&
                                 $stable(outLen))); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rstN) |-> (!outValid && inReady)); // R1

endmodule

bind instr_delimiter instr_delimiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .outForeign  (outForeign),
  .outUndef    (outUndef),
  .outHasTarget(outHasTarget),
  .outLen      (outLen),
  .outOpcode   (outOpcode),
  .outOperand  (outOperand),
  .outTarget   (outTarget),
  .outAddr     (outAddr)
);

// File: tb/instr_delimiter_tb_top.sv
module instr_delimiter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadAddr = 1'b0;
  logic [15:0] startAddr = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inByte = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outForeign, outUndef, outHasTarget;
  logic [1:0]  outLen;
  logic [7:0]  outOpcode;
  logic [15:0] outOperand, outTarget, outAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] nextAddr = '0;
  logic [60:0] recQ[$];

  always #10 clk = ~clk;

  instr_delimiter dut_i (
    .clk(clk), .rstN(rstN), .loadAddr(loadAddr), .startAddr(startAddr),
    .inValid(inValid), .inReady(inReady), .inByte(inByte),
    .outValid(outValid), .outReady(outReady), .outForeign(outForeign),
    .outUndef(outUndef), .outHasTarget(outHasTarget), .outLen(outLen),
    .outOpcode(outOpcode), .outOperand(outOperand), .outTarget(outTarget),
    .outAddr(outAddr)
  );

  always begin
    @(negedge clk);
    #8;
    if (rstN && outValid && outReady)
      recQ.push_back({outForeign, outUndef, outHasTarget, outLen, outOpcode,
                      outOperand, outTarget, outAddr});
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    #8;
    while (!inReady) begin
      @(negedge clk);
      #8;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
    nextAddr = nextAddr + 16'd1;
  endtask

  task automatic setAddr(input logic [15:0] a);
    @(negedge clk);
    loadAddr  = 1'b1;
    startAddr = a;
    @(posedge clk);
    #1;
    loadAddr = 1'b0;
    nextAddr = a;
  endtask

  task automatic expectRec(input string tag, input bit f, input bit u, input bit t,
                           input logic [1:0] len, input logic [7:0] op,
                           input logic [15:0] opnd, input logic [15:0] tgt,
                           input logic [15:0] addr);
    logic [60:0] exp;
    logic [60:0] got;
    exp = {f, u, t, len, op, opnd, tgt, addr};
    for (int i = 0; i < 40 && recQ.size() == 0; i++) @(negedge clk);
    if (recQ.size() == 0) begin
      chk(1'b0, tag, "record missing", 64'd0, 64'(exp));
    end else begin
      got = recQ.pop_front();
      chk(got == exp, tag, "record", 64'(got), 64'(exp));
    end
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R1", "outValid", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R1", "inReady", 64'(inReady), 64'd1);
  endtask

  task automatic testPassThrough();
    logic [15:0] a;
    setAddr(16'h1000);
    a = nextAddr;
    sendByte(8'h11);
    sendByte(8'h22);
    expectRec("R2", 1, 0, 0, 2'd1, 8'h11, 16'h0, 16'h0, a);
    expectRec("R9", 1, 0, 0, 2'd1, 8'h22, 16'h0, 16'h0, a + 16'd1);
  endtask

  task automatic testMarker();
    logic [15:0] a;
    a = nextAddr;
    sendByte(8'hA5); sendByte(8'h5A); sendByte(8'h77); sendByte(8'h11);
    expectRec("R3", 1, 0, 0, 2'd1, 8'hA5, 16'h0, 16'h0, a);
    expectRec("R3", 1, 0, 0, 2'd1, 8'h5A, 16'h0, 16'h0, a + 16'd1);
    expectRec("R3", 1, 0, 0, 2'd1, 8'h77, 16'h0, 16'h0, a + 16'd2);
    expectRec("R3", 1, 0, 0, 2'd1, 8'h11, 16'h0, 16'h0, a + 16'd3);
    a = nextAddr;
    sendByte(8'hA5); sendByte(8'h5A); sendByte(8'hC3);
    expectRec("R3", 1, 0, 0, 2'd1, 8'hA5, 16'h0, 16'h0, a);
    expectRec("R3", 1, 0, 0, 2'd1, 8'h5A, 16'h0, 16'h0, a + 16'd1);
    expectRec("R3", 1, 0, 0, 2'd1, 8'hC3, 16'h0, 16'h0, a + 16'd2);
  endtask

  task automatic testImmediate();
    logic [15:0] a;
    a = nextAddr;
    sendByte(8'h11); sendByte(8'h34); sendByte(8'h12);
    expectRec("R4_R11", 0, 0, 0, 2'd3, 8'h11, 16'h1234, 16'h0, a);
    a = nextAddr;
    sendByte(8'h1F); sendByte(8'hFF); sendByte(8'h00);
    expectRec("R4", 0, 0, 0, 2'd3, 8'h1F, 16'h00FF, 16'h0, a);
  endtask

  task automatic testBranch();
    setAddr(16'h2000);
    sendByte(8'h07); sendByte(8'hFD);
    expectRec("R5", 0, 0, 1, 2'd2, 8'h07, 16'h00FD, 16'h1FFF, 16'h2000);
    sendByte(8'h0C); sendByte(8'h7F);
    expectRec("R5", 0, 0, 1, 2'd2, 8'h0C, 16'h007F, 16'h2083, 16'h2002);
    setAddr(16'hFFFE);
    sendByte(8'h01); sendByte(8'h05);
    expectRec("R5_R9", 0, 0, 1, 2'd2, 8'h01, 16'h0005, 16'h0005, 16'hFFFE);
  endtask

  task automatic testOneByte();
    logic [15:0] a;
    a = nextAddr;
    sendByte(8'h41); sendByte(8'hF3); sendByte(8'h0A); sendByte(8'h0B);
    expectRec("R6", 0, 0, 0, 2'd1, 8'h41, 16'h0, 16'h0, a);
    expectRec("R6", 0, 0, 0, 2'd1, 8'hF3, 16'h0, 16'h0, a + 16'd1);
    expectRec("R6", 0, 0, 0, 2'd1, 8'h0A, 16'h0, 16'h0, a + 16'd2);
    expectRec("R6", 0, 0, 0, 2'd1, 8'h0B, 16'h0, 16'h0, a + 16'd3);
  endtask

  task automatic testUndefined();
    logic [15:0] a;
    a = nextAddr;
    sendByte(8'h0D); sendByte(8'h0F); sendByte(8'h22);
    expectRec("R7", 0, 1, 0, 2'd1, 8'h0D, 16'h0, 16'h0, a);
    expectRec("R7", 0, 1, 0, 2'd1, 8'h0F, 16'h0, 16'h0, a + 16'd1);
    expectRec("R7", 0, 0, 0, 2'd1, 8'h22, 16'h0, 16'h0, a + 16'd2);
  endtask

  task automatic testExit();
    logic [15:0] a;
    a = nextAddr;
    sendByte(8'h00); sendByte(8'h11); sendByte(8'h07);
    expectRec("R8", 0, 0, 0, 2'd1, 8'h00, 16'h0, 16'h0, a);
    expectRec("R8", 1, 0, 0, 2'd1, 8'h11, 16'h0, 16'h0, a + 16'd1);
    expectRec("R8", 1, 0, 0, 2'd1, 8'h07, 16'h0, 16'h0, a + 16'd2);
  endtask

  task automatic testBackpressure();
    logic [15:0] a;
    a = nextAddr;
    @(negedge clk);
    outReady = 1'b0;
    sendByte(8'h44);
    @(negedge clk);
    inValid = 1'b1;
    inByte  = 8'h66;
    repeat (3) @(negedge clk);
    #8;
    chk(outValid == 1'b1, "R10", "outValid held", 64'(outValid), 64'd1);
    chk(inReady == 1'b0, "R10", "inReady stalled", 64'(inReady), 64'd0);
    chk(outOpcode == 8'h44, "R10", "held opcode", 64'(outOpcode), 64'h44);
    @(negedge clk);
    outReady = 1'b1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    nextAddr = nextAddr + 16'd1;
    expectRec("R10", 1, 0, 0, 2'd1, 8'h44, 16'h0, 16'h0, a);
    expectRec("R10", 1, 0, 0, 2'd1, 8'h66, 16'h0, 16'h0, a + 16'd1);
  endtask

  task automatic testLoadWithTake();
    logic [15:0] a;
    a = nextAddr;
    @(negedge clk);
    inValid   = 1'b1;
    inByte    = 8'h55;
    loadAddr  = 1'b1;
    startAddr = 16'h3000;
    #8;
    chk(inReady == 1'b1, "R9", "ready at load", 64'(inReady), 64'd1);
    @(posedge clk);
    #1;
    inValid  = 1'b0;
    loadAddr = 1'b0;
    nextAddr = 16'h3000;
    sendByte(8'h56);
    expectRec("R9", 1, 0, 0, 2'd1, 8'h55, 16'h0, 16'h0, a);
    expectRec("R9", 1, 0, 0, 2'd1, 8'h56, 16'h0, 16'h0, 16'h3000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #8;
    testReset();
    testPassThrough();
    testMarker();
    testImmediate();
    testBranch();
    testOneByte();
    testUndefined();
    testExit();
    testBackpressure();
    testLoadWithTake();
    repeat (4) @(negedge clk);
    chk(recQ.size() == 0, "R2", "no extra records", 64'(recQ.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule